// File: doc/BRIEF.md
# AXI4 Write-Only Subordinate with Byte-Strobed Memory

This block is the write half of an AXI4 subordinate placed in front of a small on-chip memory. A manager opens a transaction with one handshake on the write address channel, which gives a start address, a beat count, a beat size and an ID. It then streams data beats on the write data channel, and each beat carries one strobe bit per byte lane. When the beat flagged as last has been accepted, the block returns a single response on the write response channel, tagged with the ID from the address phase.

Bursts always use incrementing addresses. Only one transaction is open at a time. A burst whose byte span would run past the end of the memory gets a decode-error response and changes nothing. Malformed bursts get a subordinate-error response: these are a beat count that disagrees with the flagged last beat, or a beat size wider than the data bus. Burst type, protection and cache attributes are accepted and have no effect. A combinational word-wide inspection port lets neighbouring logic read the memory contents.

Top module: `axw_write_sub`

## Requirements
- R1: After reset, `s_awready` is 1, `s_wready` is 0 and `s_bvalid` is 0.
- R2: Only one transaction is open at a time. `s_awready` goes low on the cycle after an address handshake. It stays low until the cycle after the response handshake, when it returns to 1. `s_awready` and `s_wready` are never high together.
- R3: In an accepted beat, byte lane i is `s_wdata[8i+7:8i]`. It is written to the memory word only when `s_wstrb[i]` is 1. Every other byte keeps its value. Word k can be read on `peek_data` when `peek_idx` = k, with byte lane i at the same bit position.
- R4: Let A be the start address with its low AWSIZE bits cleared. Beat n of a burst (counting from 0) goes to memory word floor((A + n*2^AWSIZE) / BUS_BYTES).
- R5: `s_bvalid` rises on the clock edge that follows the data handshake carrying `s_wlast`=1. It is never high while data beats are still being taken.
- R6: `s_bid` equals the `s_awid` captured at the address handshake of the same transaction.
- R7: If the byte range from A to A + (AWLEN+1)*2^AWSIZE - 1 reaches MEM_BYTES or beyond, the response is 2'b11 (decode error) and the memory is left unchanged. This check takes priority over the others.
- R8: If `s_wlast` comes on a beat other than beat AWLEN, the burst still ends at that beat and the response is 2'b10 (subordinate error). When the last beat comes early, every beat up to it is written. When it comes late, the beats after beat AWLEN are accepted but not written.
- R9: An in-range burst with AWSIZE greater than log2(BUS_BYTES) gets response 2'b10 and writes nothing.
- R10: Every other burst gets response 2'b00. The response 2'b01 is never produced.
- R11: While `s_bvalid` is 1 and `s_bready` is 0, `s_bvalid`, `s_bid` and `s_bresp` hold their values.
- R12: `s_awburst`, `s_awprot` and `s_awcache` have no effect on the addresses written, the data stored or the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awvalid | input | 1 | Address valid |
| s_awready | output | 1 | Address ready |
| s_awid | input | ID_W | Transaction ID |
| s_awaddr | input | ADDR_W | Start byte address |
| s_awlen | input | 8 | Beats minus one |
| s_awsize | input | 3 | log2 of bytes per beat |
| s_awburst | input | 2 | Burst type (ignored, INCR used) |
| s_awprot | input | 3 | Protection attributes (ignored) |
| s_awcache | input | 4 | Cache attributes (ignored) |
| s_wvalid | input | 1 | Data valid |
| s_wready | output | 1 | Data ready |
| s_wdata | input | 8*BUS_BYTES | Beat data |
| s_wstrb | input | BUS_BYTES | Byte-lane strobes |
| s_wlast | input | 1 | Final beat flag |
| s_bvalid | output | 1 | Response valid |
| s_bready | input | 1 | Response ready |
| s_bid | output | ID_W | Response ID |
| s_bresp | output | 2 | Response code |
| peek_idx | input | log2(MEM_BYTES/BUS_BYTES) | Inspection word index |
| peek_data | output | 8*BUS_BYTES | Inspection word data |

## Verification
The bench instantiates the block with a 4-byte bus, a 256-byte memory, 12-bit addresses and 4-bit IDs. This setting makes every beat size available: 1, 2 and 4 bytes are legal and 8 bytes is oversize. Small random addresses reach both the last word of memory and the region past it. At this memory size a single burst of 16 full beats covers a quarter of the array, so the whole memory can be compared against the bench model after every transaction. Narrow beats at unaligned start addresses exercise the alignment rule and successive beats landing in the same word.

// File: rtl/axw_pkg.sv
package axw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_RESP = 2'd2
    } axw_state_e;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_EXOKAY = 2'b01;
    localparam logic [1:0] RESP_SLVERR = 2'b10;
    localparam logic [1:0] RESP_DECERR = 2'b11;
endpackage

// File: rtl/axw_burst_check.sv
module axw_burst_check #(
    parameter int ADDR_W    = 12,
    parameter int MEM_BYTES = 256,
    parameter int BUS_BYTES = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        len,
    input  logic [2:0]        size,
    output logic [ADDR_W-1:0] start,
    output logic              in_range,
    output logic              size_ok
);
    localparam int LANE_W = $clog2(BUS_BYTES);
    localparam int SPAN_W = ADDR_W + 17;

    logic [SPAN_W-1:0] span_end;

    always_comb begin
        start    = addr & ({ADDR_W{1'b1}} << size);
        span_end = SPAN_W'(start) + ((SPAN_W'(len) + SPAN_W'(1)) << size);
        in_range = span_end <= SPAN_W'(MEM_BYTES);
        size_ok  = size <= 3'(LANE_W);
    end
endmodule

// File: rtl/axw_byte_mem.sv
module axw_byte_mem #(
    parameter int BUS_BYTES = 4,
    parameter int WORDS     = 64
) (
    input  logic                       clk,
    input  logic                       we,
    input  logic [$clog2(WORDS)-1:0]   widx,
    input  logic [BUS_BYTES*8-1:0]     wdata,
    input  logic [BUS_BYTES-1:0]       wstrb,
    input  logic [$clog2(WORDS)-1:0]   ridx,
    output logic [BUS_BYTES*8-1:0]     rdata
);
    for (genvar g = 0; g < BUS_BYTES; g++) begin : g_lane
        logic [7:0] lane_mem [WORDS];

        always_ff @(posedge clk) begin
            if (we && wstrb[g]) begin
                lane_mem[widx] <= wdata[8*g +: 8];
            end
        end

        assign rdata[8*g +: 8] = lane_mem[ridx];
    end
endmodule

// File: rtl/axw_write_sub.sv
module axw_write_sub #(
    parameter int ADDR_W    = 12,
    parameter int MEM_BYTES = 256,
    parameter int BUS_BYTES = 4,
    parameter int ID_W      = 4
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     s_awvalid,
    output logic                                     s_awready,
    input  logic [ID_W-1:0]                          s_awid,
    input  logic [ADDR_W-1:0]                        s_awaddr,
    input  logic [7:0]                               s_awlen,
    input  logic [2:0]                               s_awsize,
    input  logic [1:0]                               s_awburst,
    input  logic [2:0]                               s_awprot,
    input  logic [3:0]                               s_awcache,
    input  logic                                     s_wvalid,
    output logic                                     s_wready,
    input  logic [BUS_BYTES*8-1:0]                   s_wdata,
    input  logic [BUS_BYTES-1:0]                     s_wstrb,
    input  logic                                     s_wlast,
    output logic                                     s_bvalid,
    input  logic                                     s_bready,
    output logic [ID_W-1:0]                          s_bid,
    output logic [1:0]                               s_bresp,
    input  logic [$clog2(MEM_BYTES/BUS_BYTES)-1:0]   peek_idx,
    output logic [BUS_BYTES*8-1:0]                   peek_data
);
    import axw_pkg::*;

    localparam int WORDS  = MEM_BYTES / BUS_BYTES;
    localparam int WIDX_W = $clog2(WORDS);
    localparam int LANE_W = $clog2(BUS_BYTES);

    typedef struct packed {
        axw_state_e        st;
        logic [ID_W-1:0]   id;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        len;
        logic [2:0]        size;
        logic [7:0]        cnt;
        logic              over;
        logic              decerr;
        logic              sizeerr;
        logic [1:0]        resp;
    } axw_regs_t;

    axw_regs_t q, d;

    logic [ADDR_W-1:0] chk_start;
    logic              chk_in_range;
    logic              chk_size_ok;
    logic              mem_we;
    logic              attr_unused;

    assign attr_unused = ^{s_awburst, s_awprot, s_awcache};

    axw_burst_check #(
        .ADDR_W   (ADDR_W),
        .MEM_BYTES(MEM_BYTES),
        .BUS_BYTES(BUS_BYTES)
    ) u_check (
        .addr    (s_awaddr),
        .len     (s_awlen),
        .size    (s_awsize),
        .start   (chk_start),
        .in_range(chk_in_range),
        .size_ok (chk_size_ok)
    );

    always_comb begin
        d      = q;
        mem_we = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (s_awvalid) begin
                    d.st      = ST_DATA;
                    d.id      = s_awid;
                    d.addr    = chk_start;
                    d.len     = s_awlen;
                    d.size    = s_awsize;
                    d.cnt     = '0;
                    d.over    = 1'b0;
                    d.decerr  = !chk_in_range;
                    d.sizeerr = !chk_size_ok;
                end
            end
            ST_DATA: begin
                if (s_wvalid) begin
                    mem_we = !q.decerr && !q.sizeerr && !q.over;
                    d.addr = q.addr + (ADDR_W'(1) << q.size);
                    if (s_wlast) begin
                        d.st = ST_RESP;
                        if (q.decerr) begin
                            d.resp = RESP_DECERR;
                        end else if (q.sizeerr || q.over || (q.cnt != q.len)) begin
                            d.resp = RESP_SLVERR;
                        end else begin
                            d.resp = RESP_OKAY;
                        end
                    end else if (q.cnt == q.len) begin
                        d.over = 1'b1;
                    end else begin
                        d.cnt = q.cnt + 8'd1;
                    end
                end
            end
            ST_RESP: begin
                if (s_bready) begin
                    d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    axw_byte_mem #(
        .BUS_BYTES(BUS_BYTES),
        .WORDS    (WORDS)
    ) u_mem (
        .clk  (clk),
        .we   (mem_we),
        .widx (q.addr[LANE_W +: WIDX_W]),
        .wdata(s_wdata),
        .wstrb(s_wstrb),
        .ridx (peek_idx),
        .rdata(peek_data)
    );

    assign s_awready = (q.st == ST_IDLE);
    assign s_wready  = (q.st == ST_DATA);
    assign s_bvalid  = (q.st == ST_RESP);
    assign s_bid     = q.id;
    assign s_bresp   = q.resp;
endmodule

// File: rtl/axw_write_chk.sv
module axw_write_chk #(
    parameter int ID_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            s_awvalid,
    input logic            s_awready,
    input logic [ID_W-1:0] s_awid,
    input logic            s_wvalid,
    input logic            s_wready,
    input logic            s_wlast,
    input logic            s_bvalid,
    input logic            s_bready,
    input logic [ID_W-1:0] s_bid,
    input logic [1:0]      s_bresp
);
    logic [ID_W-1:0] id_seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_seen_q <= '0;
        end else if (s_awvalid && s_awready) begin
            id_seen_q <= s_awid;
        end
    end

    assert_addr_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid |-> !s_awready);

    assert_one_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_awready && s_wready));

    assert_resp_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_bvalid) |-> $past(s_wvalid && s_wready && s_wlast));

    assert_no_resp_in_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        s_wready |-> !s_bvalid);

    assert_id_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid |-> (s_bid == id_seen_q));

    assert_no_exokay_R10: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid |-> (s_bresp != 2'b01));

    assert_resp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid && !s_bready) |=> (s_bvalid && $stable(s_bid) && $stable(s_bresp)));
endmodule

bind axw_write_sub axw_write_chk #(.ID_W(ID_W)) u_axw_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_awvalid(s_awvalid),
    .s_awready(s_awready),
    .s_awid   (s_awid),
    .s_wvalid (s_wvalid),
    .s_wready (s_wready),
    .s_wlast  (s_wlast),
    .s_bvalid (s_bvalid),
    .s_bready (s_bready),
    .s_bid    (s_bid),
    .s_bresp  (s_bresp)
);

// File: tb/tb_axw_write_sub.sv
`timescale 1ns/1ps
module tb_axw_write_sub;
    localparam int ADDR_W    = 12;
    localparam int MEM_BYTES = 256;
    localparam int BUS_BYTES = 4;
    localparam int ID_W      = 4;
    localparam int WORDS     = MEM_BYTES / BUS_BYTES;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        awvalid = 1'b0;
    logic        awready;
    logic [3:0]  awid = '0;
    logic [11:0] awaddr = '0;
    logic [7:0]  awlen = '0;
    logic [2:0]  awsize = '0;
    logic [1:0]  awburst = 2'b01;
    logic [2:0]  awprot = '0;
    logic [3:0]  awcache = '0;
    logic        wvalid = 1'b0;
    logic        wready;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic        wlast = 1'b0;
    logic        bvalid;
    logic        bready = 1'b0;
    logic [3:0]  bid;
    logic [1:0]  bresp;
    logic [5:0]  peek_idx = '0;
    logic [31:0] peek_data;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [7:0] model [MEM_BYTES];

    always #2.5 clk = ~clk;

    axw_write_sub #(
        .ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES), .BUS_BYTES(BUS_BYTES), .ID_W(ID_W)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .s_awvalid(awvalid), .s_awready(awready), .s_awid(awid), .s_awaddr(awaddr),
        .s_awlen(awlen), .s_awsize(awsize), .s_awburst(awburst), .s_awprot(awprot),
        .s_awcache(awcache),
        .s_wvalid(wvalid), .s_wready(wready), .s_wdata(wdata), .s_wstrb(wstrb),
        .s_wlast(wlast),
        .s_bvalid(bvalid), .s_bready(bready), .s_bid(bid), .s_bresp(bresp),
        .peek_idx(peek_idx), .peek_data(peek_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_word(input int w);
        return {model[w*4+3], model[w*4+2], model[w*4+1], model[w*4]};
    endfunction

    // smode: 0 random strobes, 1 all lanes, 2 no lanes
    task automatic run_burst(input logic [3:0] id, input int addr, input int len,
                             input int size, input int nbeats, input int smode,
                             input logic [1:0] burst, input int bhold, input string tag);
        int start, span_end, exp_resp, bad_word, act_word, exp_word;
        bit in_rng, szok;
        string rq;
        start    = addr & ~((1 << size) - 1);
        span_end = start + ((len + 1) << size);
        in_rng   = span_end <= MEM_BYTES;
        szok     = size <= 2;
        if (!in_rng) begin exp_resp = 3; rq = "R7"; end
        else if (!szok) begin exp_resp = 2; rq = "R9"; end
        else if (nbeats != len + 1) begin exp_resp = 2; rq = "R8"; end
        else begin exp_resp = 0; rq = "R10"; end

        @(negedge clk);
        awvalid = 1'b1; awid = id; awaddr = addr[11:0]; awlen = len[7:0];
        awsize = size[2:0]; awburst = burst; awprot = 3'($urandom); awcache = 4'($urandom);
        while (!awready) @(negedge clk);
        @(negedge clk);
        awvalid = 1'b0;
        chk(!awready, {"R2 ", tag}, "awready after address", awready, 0);

        for (int b = 0; b < nbeats; b++) begin
            logic [31:0] dat;
            logic [3:0]  st;
            dat = $urandom;
            st  = (smode == 1) ? 4'hF : (smode == 2) ? 4'h0 : 4'($urandom);
            wvalid = 1'b1; wdata = dat; wstrb = st; wlast = (b == nbeats - 1);
            while (!wready) @(negedge clk);
            chk(!bvalid, {"R5 ", tag}, "bvalid during data", bvalid, 0);
            @(negedge clk);
            if (in_rng && szok && b <= len) begin
                int w;
                w = (start + (b << size)) / BUS_BYTES;
                for (int i = 0; i < BUS_BYTES; i++)
                    if (st[i]) model[w*4+i] = dat[8*i +: 8];
            end
        end
        wvalid = 1'b0; wlast = 1'b0;

        chk(bvalid, {"R5 ", tag}, "bvalid after last beat", bvalid, 1);
        chk(bid == id, {"R6 ", tag}, "bid", bid, id);
        chk(bresp == 2'(exp_resp), {rq, " ", tag}, "bresp", bresp, exp_resp);
        for (int h = 0; h < bhold; h++) begin
            @(negedge clk);
            chk(bvalid && bid == id && bresp == 2'(exp_resp), {"R11 ", tag},
                "response held", {bvalid, bid, bresp}, {1'b1, id, 2'(exp_resp)});
        end
        bready = 1'b1;
        @(negedge clk);
        bready = 1'b0;
        chk(!bvalid && awready, {"R2 ", tag}, "idle after response",
            {bvalid, awready}, 2'b01);

        bad_word = -1; act_word = 0; exp_word = 0;
        for (int w = 0; w < WORDS; w++) begin
            peek_idx = 6'(w);
            #0.02;
            if (bad_word < 0 && peek_data !== model_word(w)) begin
                bad_word = w; act_word = peek_data; exp_word = model_word(w);
            end
        end
        chk(bad_word < 0, {"R3 R4 ", rq, " ", tag}, $sformatf("memory word %0d", bad_word),
            act_word, exp_word);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0A17));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(awready && !wready && !bvalid, "R1", "reset outputs",
            {awready, wready, bvalid}, 3'b100);

        // fill whole memory with full-strobe bursts so the model is known
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < 64; i++) model[k*64+i] = 8'h00;
        end
        for (int k = 0; k < 4; k++) run_burst(4'(k + 1), k * 64, 15, 2, 16, 1, 2'b01, 0, "fill");

        run_burst(4'h3, 8, 0, 2, 1, 0, 2'b01, 0, "R3 random lanes");
        run_burst(4'h4, 12, 0, 2, 1, 2, 2'b01, 0, "R3 no lanes");
        run_burst(4'h5, 'h21, 3, 0, 4, 0, 2'b01, 0, "R4 byte beats unaligned");
        run_burst(4'h6, 'h42, 2, 1, 3, 0, 2'b01, 0, "R4 halfword beats");
        run_burst(4'h7, 252, 0, 2, 1, 1, 2'b01, 0, "R10 last word fits");
        run_burst(4'h8, 252, 1, 2, 2, 1, 2'b01, 0, "R7 one word over");
        run_burst(4'h9, 4000, 0, 0, 1, 1, 2'b01, 0, "R7 far address");
        run_burst(4'hA, 16, 3, 2, 2, 1, 2'b01, 0, "R8 early last");
        run_burst(4'hB, 32, 1, 2, 4, 1, 2'b01, 0, "R8 late last");
        run_burst(4'hC, 0, 0, 3, 1, 1, 2'b01, 0, "R9 oversize beat");
        run_burst(4'hD, 100, 2, 2, 3, 1, 2'b10, 0, "R12 wrap type");
        run_burst(4'hE, 140, 1, 1, 2, 0, 2'b00, 0, "R12 fixed type");
        run_burst(4'hF, 60, 0, 2, 1, 1, 2'b01, 6, "R11 long hold");

        for (int t = 0; t < 80; t++) begin
            int len, size, nb, addr;
            len  = $urandom % 8;
            size = ($urandom % 10 == 0) ? 3 : $urandom % 3;
            addr = $urandom % 320;
            nb   = ($urandom % 8 == 0) ? 1 + ($urandom % (len + 3)) : len + 1;
            run_burst(4'($urandom), addr, len, size, nb, 0, 2'($urandom),
                      $urandom % 3, "random");
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule